// File: doc/BRIEF.md
# Datapath Self-Test Engine

This block checks the digital half of a two-channel sampling datapath without any analog stimulus. On request it replaces the converter words at the head of the datapath with words from a 16-bit pseudorandom generator, for a fixed run of 512 words. It folds every such word that leaves the datapath into a 16-bit multiple-input signature register. When the last test word has left, it compares the signature with a stored expected value and raises a pass flag if they match. The datapath under test is modelled as a fixed-latency register pipeline with an optional output coding step. Test words still reach the output port, so the sequence can be watched while it runs.

Sample words enter and leave through valid/ready streams. The whole pipeline advances only in cycles where `dout_ready` is high. While `dout_valid` is high and `dout_ready` is low, the output word is held unchanged. `din_ready` is low whenever the output is stalled or a test is running, so host words are never dropped. A small byte-wide register port starts the test and reads back the control bits, the status flags and the signature.

Top module: `dp_selftest`

## Requirements
- R1: After reset, `dout_valid`, `busy` and `pass` are 0. The control register reads 0x00, and the signature low and high bytes read 0xFF each.
- R2: With no test running, words accepted on `din_valid && din_ready` leave on `dout_data` in order after LAT pipeline advances. When `fmt_twos` is 1, bits 7 and 15 of each output word are inverted.
- R3: While `dout_valid` is 1 and `dout_ready` is 0, the next cycle shows the same `dout_data` with `dout_valid` still 1. `din_ready` is 0 whenever `dout_ready` is 0 or `busy` is 1.
- R4: A write to the control address 0x10 with bit 0 (enable) set, made while idle, starts a test. It sets the signature to 0xFFFF and clears `pass`. If bit 2 (init) is also set, the generator is reloaded with SEED. `busy` is 1 from the cycle after that write until the last test word has left the output.
- R5: A test injects exactly 512 words, one per pipeline advance. Each word is the generator state before it steps. The high byte carries channel A and the low byte carries channel B. A step shifts the state left by one and feeds bit 15 ^ bit 13 ^ bit 12 ^ bit 10 into bit 0. The injected words appear on `dout_data`, after the same output coding as host words.
- R6: For each test word W accepted at the output, the signature S becomes (S << 1) ^ (S[15] ? 0x1021 : 0) ^ W.
- R7: At the end of a test, the enable bit clears by itself and `pass` becomes 1 exactly when the final signature equals EXP_SIG. `pass` and the signature then hold until the next test starts, and `pass` stays 0 while a test runs.
- R8: A test started with init = 0 continues the generator from the state that follows the last word of the previous test.
- R9: Control writes made while `busy` is 1 have no effect: the running sequence, the test length and the control readback are unchanged.
- R10: The read port returns the following values. Address 0x10 gives {5'b0, init, 1'b0, enable}. Address 0x11 gives {6'b0, busy, pass}. Addresses 0x24 and 0x25 give the low and high signature bytes. Any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| din_valid | input | 1 | Host sample word valid |
| din_ready | output | 1 | Host sample word accepted this cycle |
| din_data | input | 16 | Host sample word, channel A high byte, channel B low byte |
| dout_valid | output | 1 | Output word valid |
| dout_ready | input | 1 | Consumer takes the output word; advances the pipeline |
| dout_data | output | 16 | Output word after coding |
| fmt_twos | input | 1 | Invert each channel's top bit at the output |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 8 | Register read address |
| rd_data | output | 8 | Register read data, combinational |
| busy | output | 1 | Test in progress |
| pass | output | 1 | Result of the most recent test |

## Verification
Some properties are checked by assertions on every cycle. These are: the output holds its word while stalled; every run delivers exactly 512 tagged words before `busy` falls; the enable bit is clear whenever a run ends; `pass` stays low during a run; and `pass` and the signature are frozen while idle. Other behaviours need the bench's scenarios, which compare against an independent model. These are: the exact pseudorandom words and their order; the signature arithmetic and the pass decision; the generator carrying on across a run without init; the stray control write in mid-run being ignored; and the output coding.

// File: rtl/dst_pkg.sv
package dst_pkg;
  localparam int CH_W     = 8;
  localparam int N_CH     = 2;
  localparam int WORD_W   = CH_W * N_CH;
  localparam logic [WORD_W-1:0] SIG_POLY = 16'h1021;
  localparam logic [WORD_W-1:0] SIG_INIT = 16'hFFFF;

  typedef enum logic [1:0] {ST_IDLE, ST_INJ, ST_DRAIN} run_st_t;

  function automatic logic [WORD_W-1:0] lfsr_step(input logic [WORD_W-1:0] s);
    return {s[WORD_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  function automatic logic [WORD_W-1:0] misr_step(input logic [WORD_W-1:0] s,
                                                  input logic [WORD_W-1:0] w);
    logic [WORD_W-1:0] sh;
    sh = {s[WORD_W-2:0], 1'b0};
    if (s[WORD_W-1]) sh = sh ^ SIG_POLY;
    return sh ^ w;
  endfunction

  function automatic logic [WORD_W-1:0] top_bit_mask();
    logic [WORD_W-1:0] m;
    m = '0;
    for (int c = 0; c < N_CH; c++) m[c*CH_W + CH_W - 1] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/dst_pn_src.sv
module dst_pn_src
  import dst_pkg::*;
#(
  parameter logic [WORD_W-1:0] SEED = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reseed,
  input  logic              step,
  output logic [WORD_W-1:0] word
);
  logic [WORD_W-1:0] state_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      state_q <= SEED;
    else if (reseed) state_q <= SEED;
    else if (step)   state_q <= lfsr_step(state_q);
  end

  assign word = state_q;
endmodule

// File: rtl/dst_pipe.sv
module dst_pipe
  import dst_pkg::*;
#(
  parameter int LAT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              in_v,
  input  logic              in_tag,
  input  logic [WORD_W-1:0] in_d,
  input  logic              fmt_twos,
  output logic              out_v,
  output logic              out_tag,
  output logic [WORD_W-1:0] out_d
);
  localparam logic [WORD_W-1:0] FMT_MASK = top_bit_mask();

  logic              v_q [LAT];
  logic              t_q [LAT];
  logic [WORD_W-1:0] d_q [LAT];

  for (genvar g = 0; g < LAT; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          v_q[g] <= 1'b0;
          t_q[g] <= 1'b0;
          d_q[g] <= '0;
        end else if (adv) begin
          v_q[g] <= in_v;
          t_q[g] <= in_tag & in_v;
          d_q[g] <= in_d;
        end
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          v_q[g] <= 1'b0;
          t_q[g] <= 1'b0;
          d_q[g] <= '0;
        end else if (adv) begin
          v_q[g] <= v_q[g-1];
          t_q[g] <= t_q[g-1];
          d_q[g] <= d_q[g-1];
        end
      end
    end
  end

  assign out_v   = v_q[LAT-1];
  assign out_tag = t_q[LAT-1];
  assign out_d   = d_q[LAT-1] ^ (fmt_twos ? FMT_MASK : '0);
endmodule

// File: rtl/dst_sig.sv
module dst_sig
  import dst_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              cap,
  input  logic [WORD_W-1:0] word,
  output logic [WORD_W-1:0] sig,
  output logic [WORD_W-1:0] sig_nxt
);
  logic [WORD_W-1:0] sig_q;

  assign sig_nxt = misr_step(sig_q, word);

  always_ff @(posedge clk) begin
    if (!rst_n)     sig_q <= SIG_INIT;
    else if (clear) sig_q <= SIG_INIT;
    else if (cap)   sig_q <= sig_nxt;
  end

  assign sig = sig_q;
endmodule

// File: rtl/dst_ctrl.sv
module dst_ctrl
  import dst_pkg::*;
#(
  parameter int                LEN       = 512,
  parameter logic [WORD_W-1:0] EXP_SIG   = 16'h0000,
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h10,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h11,
  parameter logic [ADDR_W-1:0] SIGL_ADDR = 8'h24,
  parameter logic [ADDR_W-1:0] SIGH_ADDR = 8'h25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  input  logic              adv,
  input  logic              out_cap,
  input  logic [WORD_W-1:0] sig,
  input  logic [WORD_W-1:0] sig_nxt,
  output logic              start,
  output logic              reseed,
  output logic              inj,
  output logic              busy,
  output logic              pass,
  output logic              en_bit
);
  localparam int CW = $clog2(LEN + 1);
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  run_st_t       st_q;
  logic          en_q, init_q, pass_q;
  logic [CW-1:0] in_cnt, out_cnt;
  logic          ctrl_hit, last_in, done;
  logic          unused_wr_bits;

  assign unused_wr_bits = ^{wr_data[7:3], wr_data[1]};

  assign ctrl_hit = wr_en && (wr_addr == CTRL_ADDR);
  assign start    = ctrl_hit && wr_data[0] && (st_q == ST_IDLE);
  assign reseed   = start && wr_data[2];
  assign inj      = (st_q == ST_INJ);
  assign busy     = (st_q != ST_IDLE);
  assign last_in  = inj && adv && (in_cnt == LAST);
  assign done     = out_cap && (out_cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      en_q    <= 1'b0;
      init_q  <= 1'b0;
      pass_q  <= 1'b0;
      in_cnt  <= '0;
      out_cnt <= '0;
    end else begin
      if (ctrl_hit && (st_q == ST_IDLE)) begin
        en_q   <= wr_data[0];
        init_q <= wr_data[2];
      end
      if (start) begin
        st_q    <= ST_INJ;
        in_cnt  <= '0;
        out_cnt <= '0;
        pass_q  <= 1'b0;
      end else begin
        if (inj && adv) in_cnt <= in_cnt + 1'b1;
        if (last_in)    st_q   <= ST_DRAIN;
        if (out_cap)    out_cnt <= out_cnt + 1'b1;
        if (done) begin
          st_q   <= ST_IDLE;
          en_q   <= 1'b0;
          pass_q <= (sig_nxt == EXP_SIG);
        end
      end
    end
  end

  assign pass   = pass_q;
  assign en_bit = en_q;

  always_comb begin
    rd_data = 8'h00;
    if (rd_addr == CTRL_ADDR)      rd_data = {5'b0, init_q, 1'b0, en_q};
    else if (rd_addr == STAT_ADDR) rd_data = {6'b0, busy, pass_q};
    else if (rd_addr == SIGL_ADDR) rd_data = sig[7:0];
    else if (rd_addr == SIGH_ADDR) rd_data = sig[15:8];
  end
endmodule

// File: rtl/dp_selftest.sv
module dp_selftest
  import dst_pkg::*;
#(
  parameter int                LAT       = 3,
  parameter int                LEN       = 512,
  parameter logic [15:0]       SEED      = 16'hACE1,
  parameter logic [15:0]       EXP_SIG   = 16'h0000,
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h10,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h11,
  parameter logic [ADDR_W-1:0] SIGL_ADDR = 8'h24,
  parameter logic [ADDR_W-1:0] SIGH_ADDR = 8'h25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              din_valid,
  output logic              din_ready,
  input  logic [15:0]       din_data,
  output logic              dout_valid,
  input  logic              dout_ready,
  output logic [15:0]       dout_data,
  input  logic              fmt_twos,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              busy,
  output logic              pass
);
  logic              adv, inj, start, reseed, en_bit;
  logic              out_tag, out_cap;
  logic [WORD_W-1:0] pn_word, head_d, sig, sig_nxt;
  logic              head_v;

  assign adv       = dout_ready;
  assign din_ready = dout_ready && !busy;
  assign head_v    = inj ? 1'b1 : (din_valid && din_ready);
  assign head_d    = inj ? pn_word : din_data;
  assign out_cap   = dout_valid && dout_ready && out_tag;

  dst_pn_src #(.SEED(SEED)) i_pn (
    .clk(clk), .rst_n(rst_n), .reseed(reseed), .step(inj && adv), .word(pn_word)
  );

  dst_pipe #(.LAT(LAT)) i_pipe (
    .clk(clk), .rst_n(rst_n), .adv(adv), .in_v(head_v), .in_tag(inj),
    .in_d(head_d), .fmt_twos(fmt_twos), .out_v(dout_valid),
    .out_tag(out_tag), .out_d(dout_data)
  );

  dst_sig i_sig (
    .clk(clk), .rst_n(rst_n), .clear(start), .cap(out_cap),
    .word(dout_data), .sig(sig), .sig_nxt(sig_nxt)
  );

  dst_ctrl #(
    .LEN(LEN), .EXP_SIG(EXP_SIG), .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR),
    .STAT_ADDR(STAT_ADDR), .SIGL_ADDR(SIGL_ADDR), .SIGH_ADDR(SIGH_ADDR)
  ) i_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .adv(adv),
    .out_cap(out_cap), .sig(sig), .sig_nxt(sig_nxt), .start(start),
    .reseed(reseed), .inj(inj), .busy(busy), .pass(pass), .en_bit(en_bit)
  );
endmodule

// File: rtl/dst_chk.sv
module dst_chk #(
  parameter int LEN = 512
) (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        pass,
  input logic        en_bit,
  input logic        out_cap,
  input logic        dout_valid,
  input logic        dout_ready,
  input logic [15:0] dout_data,
  input logic [15:0] sig
);
  localparam int CW = $clog2(LEN + 2);
  logic [CW-1:0] seen_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !busy) seen_q <= '0;
    else if (out_cap)    seen_q <= seen_q + 1'b1;
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_valid && !dout_ready) |=> (dout_valid && $stable(dout_data))); // R3

  AST_RUN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (seen_q == CW'(LEN))); // R5

  AST_EN_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !en_bit); // R7

  AST_PASS_LOW_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !pass); // R4

  AST_PASS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> $stable(pass)); // R7

  AST_SIG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> $stable(sig)); // R7
endmodule

bind dp_selftest dst_chk #(.LEN(LEN)) i_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .pass(pass), .en_bit(en_bit),
  .out_cap(out_cap), .dout_valid(dout_valid), .dout_ready(dout_ready),
  .dout_data(dout_data), .sig(sig)
);

// File: tb/test_dp_selftest.sv
module test_dp_selftest;
  localparam int          LAT     = 3;
  localparam int          RUN_LEN = 512;
  localparam logic [15:0] SEED    = 16'hACE1;
  localparam logic [15:0] TOPS    = 16'h8080;

  function automatic logic [15:0] m_pn(input logic [15:0] s);
    logic fb;
    fb = s[15] ^ s[13] ^ s[12] ^ s[10];
    return (s << 1) | {15'b0, fb};
  endfunction

  function automatic logic [15:0] m_fold(input logic [15:0] s, input logic [15:0] w);
    logic [15:0] r;
    r = s << 1;
    if (s[15]) r = r ^ 16'h1021;
    return r ^ w;
  endfunction

  function automatic logic [15:0] m_gold();
    logic [15:0] s, p;
    s = 16'hFFFF;
    p = SEED;
    for (int i = 0; i < RUN_LEN; i++) begin
      s = m_fold(s, p);
      p = m_pn(p);
    end
    return s;
  endfunction

  localparam logic [15:0] GOLD = m_gold();

  logic clk = 1'b0, rst_n = 1'b0;
  logic din_valid = 1'b0, dout_ready = 1'b1, fmt_twos = 1'b0;
  logic [15:0] din_data = '0;
  logic wr_en = 1'b0;
  logic [7:0] wr_addr = '0, wr_data = '0, rd_addr = '0;
  logic din_ready, dout_valid, busy, pass;
  logic [15:0] dout_data;
  logic [7:0] rd_data;

  int n_chk = 0, n_bad = 0, n_out = 0;
  logic [15:0] exp_q[$];
  logic [15:0] pn_m = SEED;
  logic [15:0] sig_m = 16'hFFFF;

  always #10 clk = ~clk;

  dp_selftest #(.LAT(LAT), .LEN(RUN_LEN), .SEED(SEED), .EXP_SIG(GOLD)) i_dp_selftest (
    .clk(clk), .rst_n(rst_n), .din_valid(din_valid), .din_ready(din_ready),
    .din_data(din_data), .dout_valid(dout_valid), .dout_ready(dout_ready),
    .dout_data(dout_data), .fmt_twos(fmt_twos), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .pass(pass)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  // monitor: pops the scoreboard on each output handshake
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && dout_valid && dout_ready) begin
        n_out++;
        if (exp_q.size() == 0) chk("R5", "unexpected output word", {16'hDEAD, dout_data}, {16'h0, dout_data});
        else chk("R5", "output word", dout_data, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk("R4", "watchdog expired", 1, 0);
    finish_run();
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(posedge clk); #2;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #2;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic send(input logic [15:0] w);
    @(posedge clk); #2;
    din_valid = 1'b1; din_data = w;
    exp_q.push_back(w ^ (fmt_twos ? TOPS : 16'h0));
    @(posedge clk); #2;
    din_valid = 1'b0;
  endtask

  task automatic wait_idle(input bit bp);
    int k;
    bit ended;
    k = 0; ended = 0;
    for (int i = 0; i < 4000; i++) begin
      @(posedge clk); #2;
      if (!busy) begin ended = 1; break; end
      dout_ready = bp ? ((k % 3) != 2) : 1'b1;
      k++;
    end
    dout_ready = 1'b1;
    chk("R4", "run ends", ended, 1);
  endtask

  task automatic run_test(input bit init, input bit bp);
    logic [7:0] d;
    int n0;
    logic exp_pass;
    if (init) pn_m = SEED;
    sig_m = 16'hFFFF;
    for (int i = 0; i < RUN_LEN; i++) begin
      logic [15:0] w;
      w = pn_m ^ (fmt_twos ? TOPS : 16'h0);
      exp_q.push_back(w);
      sig_m = m_fold(sig_m, w);
      pn_m = m_pn(pn_m);
    end
    exp_pass = (sig_m == GOLD);
    n0 = n_out;
    wr(8'h10, init ? 8'h05 : 8'h01);
    chk("R4", "busy after start", busy, 1);
    chk("R4", "pass cleared at start", pass, 0);
    chk("R3", "din_ready low while busy", din_ready, 0);
    rd(8'h10, d);
    chk("R10", "control readback in run", d, {5'b0, init, 2'b01});
    wr(8'h10, 8'h05);  // R9: stray write in mid-run
    rd(8'h10, d);
    chk("R9", "control unchanged by write in run", d, {5'b0, init, 2'b01});
    wait_idle(bp);
    chk("R5", "test words delivered", n_out - n0, RUN_LEN);
    chk("R5", "scoreboard drained", exp_q.size(), 0);
    chk("R7", "pass decision", pass, exp_pass);
    rd(8'h10, d);
    chk("R7", "enable self-cleared", d, {5'b0, init, 2'b00});
    rd(8'h24, d);
    chk("R6", "signature low byte", d, sig_m[7:0]);
    rd(8'h25, d);
    chk("R6", "signature high byte", d, sig_m[15:8]);
    rd(8'h11, d);
    chk("R10", "status readback", d, {6'b0, 1'b0, exp_pass});
    repeat (10) @(posedge clk);
    #2;
    chk("R7", "pass held while idle", pass, exp_pass);
    chk("R3", "no output after run", dout_valid, 0);
  endtask

  initial begin
    logic [7:0] d;
    repeat (3) @(posedge clk);
    #2;
    chk("R1", "dout_valid after reset", dout_valid, 0);
    chk("R1", "busy after reset", busy, 0);
    chk("R1", "pass after reset", pass, 0);
    rd(8'h10, d); chk("R1", "control after reset", d, 8'h00);
    rd(8'h24, d); chk("R1", "signature low after reset", d, 8'hFF);
    rd(8'h25, d); chk("R1", "signature high after reset", d, 8'hFF);
    rd(8'h33, d); chk("R10", "unmapped address", d, 8'h00);
    @(posedge clk); #2;
    rst_n = 1'b1;
    chk("R1", "dout_valid out of reset", dout_valid, 0);
    chk("R3", "din_ready idle", din_ready, 1);

    // R2: host passthrough, plain and recoded
    send(16'h1234); send(16'h00FF); send(16'h8001); send(16'hA55A); send(16'h7F80);
    repeat (LAT + 3) @(posedge clk);
    fmt_twos = 1'b1;
    send(16'h0000); send(16'hFFFF); send(16'h7F7F);
    repeat (LAT + 3) @(posedge clk);
    fmt_twos = 1'b0;
    chk("R2", "host words all seen", exp_q.size(), 0);

    run_test(1'b1, 1'b0);   // R4 R5 R6 R7 with init
    run_test(1'b0, 1'b0);   // R8 generator continues, signature differs
    run_test(1'b1, 1'b1);   // R3 back-pressure during a run
    fmt_twos = 1'b1;
    run_test(1'b1, 1'b0);   // R2 coding applied to test words
    fmt_twos = 1'b0;

    finish_run();
  end
endmodule